// File: doc/BRIEF.md
# Multicycle 24-bit Accumulator Processor Core

This block is a small processor core built around a 24-bit accumulator. It talks to a byte-wide synchronous memory through a single read/write port. It fetches each 3-byte instruction one byte per cycle and splits it into an opcode, an index flag and a 15-bit address. It then runs the instruction over several more cycles. The instruction set covers word load and store for the accumulator, index and link registers, and single-byte load and store of the accumulator's low byte. It also has add, subtract, AND and OR, a signed compare, and an increment-and-compare on the index register. Control flow is three conditional jumps, an unconditional jump, and a subroutine call and return.

The core is meant to sit beside an on-chip byte RAM, with read data returned one cycle after the request. A word is three consecutive bytes with the most significant byte at the lowest address. Compare results are kept as a 2-bit condition code, which is shown on an output. An opcode outside the defined set stops the core: it sets `halted` and leaves it set until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low (sampled synchronously) the core clears A, X, L, PC and the condition code to zero and drives `halted` low. The first cycle after reset requests a read at address 0.
- R2: An instruction is fetched with byte reads at PC, PC+1 and PC+2 in consecutive cycles. The bytes are assembled big-endian: bits 23..16 are the opcode, bit 15 is the index flag and bits 14..0 are the address field. PC then advances by 3.
- R3: The effective address is the address field when the index flag is 0. When the flag is 1 it is the address field plus X, truncated to 15 bits so that it wraps.
- R4: Word loads copy the 3-byte word at the effective address into a register: opcode 0x01 loads A, 0x02 loads X, 0x03 loads L. Word stores write the register as three bytes, most significant byte at the lowest address: 0x04 stores A, 0x05 stores X, 0x06 stores L.
- R5: Opcodes 0x10, 0x11, 0x12 and 0x13 replace A with A+M, A−M, A AND M and A OR M, where M is the memory word. Results are taken modulo 2^24.
- R6: Opcode 0x20 compares A with the memory word as signed 24-bit values. It sets the condition code to 00 for less, 01 for equal and 10 for greater. The value 11 never appears.
- R7: Opcode 0x21 first increments X by 1, modulo 2^24. It then compares the new X with the memory word, signed, and sets the condition code as in R6.
- R8: Opcode 0x30 always loads PC with the effective address. Opcodes 0x31, 0x32 and 0x33 do so only when the condition code is less, equal or greater respectively. Otherwise execution continues at the next instruction.
- R9: Opcode 0x34 copies the already advanced PC (the address after the call) into L, then loads PC with the effective address. Opcode 0x35 loads PC from L.
- R10: Opcode 0x07 replaces only bits 7..0 of A with the byte at the effective address and leaves bits 23..8 unchanged. Opcode 0x08 writes A bits 7..0 to that one byte and leaves the neighbouring bytes untouched.
- R11: Any other opcode sets `halted` once its fetch completes. From then on the core makes no memory access and `halted` stays high until reset.
- R12: Read enable and write enable are never both high in one cycle. Back-to-back reads, and back-to-back writes, go to consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address of the current memory access |
| mem_rd_en | output | 1 | Read request; data is returned on the next cycle |
| mem_rdata | input | 8 | Read data for the request made in the previous cycle |
| mem_wr_en | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to be written |
| halted | output | 1 | High once an undefined opcode has been executed |
| cond_code | output | 2 | Current condition code: 00 less, 01 equal, 10 greater |

## Verification
The bench builds the core with its default parameters: 8-bit bytes, a 15-bit address and 3-byte words. The bench memory covers the whole 32 KB space, which lets the index wrap at the top of the address range be tested. Every one of the 256 opcode values is run, separating the defined set from the halting set. Arithmetic, compare and increment-and-compare are swept over every pair from a set of eight operands. These operands include zero, both signed extremes and all-ones, so carries, borrows and sign boundaries are all exercised. Each compare outcome is sent through both jump orderings.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator core: opcode values, decoded
// instruction record, condition code values and controller states.
// Assumes 8-bit opcodes; other widths come from top parameters.
package acc_pkg;

    localparam logic [7:0] OP_LDA  = 8'h01;
    localparam logic [7:0] OP_LDX  = 8'h02;
    localparam logic [7:0] OP_LDL  = 8'h03;
    localparam logic [7:0] OP_STA  = 8'h04;
    localparam logic [7:0] OP_STX  = 8'h05;
    localparam logic [7:0] OP_STL  = 8'h06;
    localparam logic [7:0] OP_LDB  = 8'h07;
    localparam logic [7:0] OP_STB  = 8'h08;
    localparam logic [7:0] OP_ADD  = 8'h10;
    localparam logic [7:0] OP_SUB  = 8'h11;
    localparam logic [7:0] OP_AND  = 8'h12;
    localparam logic [7:0] OP_OR   = 8'h13;
    localparam logic [7:0] OP_CMP  = 8'h20;
    localparam logic [7:0] OP_INCX = 8'h21;
    localparam logic [7:0] OP_JMP  = 8'h30;
    localparam logic [7:0] OP_JLT  = 8'h31;
    localparam logic [7:0] OP_JEQ  = 8'h32;
    localparam logic [7:0] OP_JGT  = 8'h33;
    localparam logic [7:0] OP_CALL = 8'h34;
    localparam logic [7:0] OP_RET  = 8'h35;

    localparam logic [1:0] CC_LT = 2'b00;
    localparam logic [1:0] CC_EQ = 2'b01;
    localparam logic [1:0] CC_GT = 2'b10;

    typedef enum logic [3:0] {
        K_LOAD, K_STORE, K_ALU, K_CMP, K_INCX, K_JUMP,
        K_CALL, K_RET, K_LDB, K_STB, K_BAD
    } kind_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_t;
    typedef enum logic [1:0] {JC_ALL, JC_LT, JC_EQ, JC_GT} jcond_t;
    typedef enum logic [1:0] {RS_A, RS_X, RS_L} rsel_t;

    typedef struct packed {
        kind_t   kind;
        rsel_t   rsel;
        alu_op_t aop;
        jcond_t  jc;
    } dec_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_MEMRD, ST_MEMWR, ST_EXEC, ST_HALT
    } state_t;

endpackage

// File: rtl/acc_decode.sv
// Opcode decoder: maps the 8-bit opcode to an instruction class,
// a register select, an ALU operation and a jump condition.
// Assumes nothing about timing; purely combinational.
module acc_decode
    import acc_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    // Classify the opcode; anything not listed is K_BAD.
    always_comb begin
        dec = '{kind: K_BAD, rsel: RS_A, aop: ALU_ADD, jc: JC_ALL};
        case (opcode)
            OP_LDA:  dec.kind = K_LOAD;
            OP_LDX:  begin dec.kind = K_LOAD;  dec.rsel = RS_X; end
            OP_LDL:  begin dec.kind = K_LOAD;  dec.rsel = RS_L; end
            OP_STA:  dec.kind = K_STORE;
            OP_STX:  begin dec.kind = K_STORE; dec.rsel = RS_X; end
            OP_STL:  begin dec.kind = K_STORE; dec.rsel = RS_L; end
            OP_LDB:  dec.kind = K_LDB;
            OP_STB:  dec.kind = K_STB;
            OP_ADD:  dec.kind = K_ALU;
            OP_SUB:  begin dec.kind = K_ALU;  dec.aop = ALU_SUB; end
            OP_AND:  begin dec.kind = K_ALU;  dec.aop = ALU_AND; end
            OP_OR:   begin dec.kind = K_ALU;  dec.aop = ALU_OR;  end
            OP_CMP:  dec.kind = K_CMP;
            OP_INCX: dec.kind = K_INCX;
            OP_JMP:  dec.kind = K_JUMP;
            OP_JLT:  begin dec.kind = K_JUMP; dec.jc = JC_LT; end
            OP_JEQ:  begin dec.kind = K_JUMP; dec.jc = JC_EQ; end
            OP_JGT:  begin dec.kind = K_JUMP; dec.jc = JC_GT; end
            OP_CALL: dec.kind = K_CALL;
            OP_RET:  dec.kind = K_RET;
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
// Arithmetic/logic unit and signed comparator for the core.
// Assumes two's complement operands of W bits; results wrap modulo 2^W.
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [W-1:0] cmp_lhs,
    input  alu_op_t      op,
    output logic [W-1:0] res,
    output logic [1:0]   cc
);

    // Compute the selected arithmetic or logic result.
    always_comb begin
        case (op)
            ALU_ADD: res = lhs + rhs;
            ALU_SUB: res = lhs - rhs;
            ALU_AND: res = lhs & rhs;
            default: res = lhs | rhs;
        endcase
    end

    // Signed three-way comparison into the condition code.
    always_comb begin
        if ($signed(cmp_lhs) < $signed(rhs))
            cc = CC_LT;
        else if (cmp_lhs == rhs)
            cc = CC_EQ;
        else
            cc = CC_GT;
    end

endmodule

// File: rtl/acc_core.sv
// Multicycle accumulator core. Fetches 3-byte big-endian instructions
// one byte per cycle, reads or writes operands byte-serially and
// executes one instruction at a time.
// Assumes a memory returning read data one cycle after mem_rd_en and
// committing writes at the clock edge where mem_wr_en is high.
module acc_core
    import acc_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 15,
    parameter int WORD_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              halted,
    output logic [1:0]        cond_code
);

    localparam int W     = BYTE_W * WORD_BYTES;
    localparam int CNT_W = $clog2(WORD_BYTES + 1);
    localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BYTES - 1);

    logic [W-1:0]      a_q, x_q, l_q, pc_q, ir_q, mdr_q;
    logic [1:0]        cc_q;
    logic [ADDR_W-1:0] ea_q, ea_next;
    logic [CNT_W-1:0]  cnt_q, xfer_len, byte_sel;
    state_t            st_q;
    dec_t              dec;
    logic              is_byte, jmp_taken;
    logic [W-1:0]      store_val, x_inc, cmp_lhs, alu_res;
    logic [1:0]        alu_cc;

    acc_decode u_dec (
        .opcode (ir_q[W-1 -: 8]),
        .dec    (dec)
    );

    acc_alu #(.W(W)) u_alu (
        .lhs     (a_q),
        .rhs     (mdr_q),
        .cmp_lhs (cmp_lhs),
        .op      (dec.aop),
        .res     (alu_res),
        .cc      (alu_cc)
    );

    // Operand selection, effective address and transfer length.
    always_comb begin
        is_byte  = (dec.kind == K_LDB) || (dec.kind == K_STB);
        xfer_len = (st_q == ST_FETCH || !is_byte) ? WORD_LEN : CNT_W'(1);
        ea_next  = ir_q[ADDR_W-1:0] + (ir_q[ADDR_W] ? x_q[ADDR_W-1:0] : '0);
        x_inc    = x_q + W'(1);
        cmp_lhs  = (dec.kind == K_INCX) ? x_inc : a_q;
        case (dec.rsel)
            RS_X:    store_val = x_q;
            RS_L:    store_val = l_q;
            default: store_val = a_q;
        endcase
        case (dec.jc)
            JC_LT:   jmp_taken = (cc_q == CC_LT);
            JC_EQ:   jmp_taken = (cc_q == CC_EQ);
            JC_GT:   jmp_taken = (cc_q == CC_GT);
            default: jmp_taken = 1'b1;
        endcase
    end

    // Memory port drive: address, strobes and write byte.
    always_comb begin
        byte_sel  = LAST_IDX - cnt_q;
        mem_addr  = ((st_q == ST_FETCH) ? pc_q[ADDR_W-1:0] : ea_q) + ADDR_W'(cnt_q);
        mem_rd_en = ((st_q == ST_FETCH) || (st_q == ST_MEMRD)) && (cnt_q != xfer_len);
        mem_wr_en = (st_q == ST_MEMWR);
        mem_wdata = is_byte ? a_q[BYTE_W-1:0] : store_val[byte_sel*BYTE_W +: BYTE_W];
        halted    = (st_q == ST_HALT);
        cond_code = cc_q;
    end

    // Controller and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            x_q   <= '0;
            l_q   <= '0;
            pc_q  <= '0;
            ir_q  <= '0;
            mdr_q <= '0;
            cc_q  <= CC_LT;
            ea_q  <= '0;
            cnt_q <= '0;
            st_q  <= ST_FETCH;
        end else begin
            case (st_q)
                ST_FETCH: begin
                    if (cnt_q != '0)
                        ir_q <= {ir_q[W-BYTE_W-1:0], mem_rdata};
                    if (cnt_q == WORD_LEN) begin
                        cnt_q <= '0;
                        pc_q  <= pc_q + W'(WORD_BYTES);
                        st_q  <= ST_DECODE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DECODE: begin
                    ea_q  <= ea_next;
                    cnt_q <= '0;
                    case (dec.kind)
                        K_LOAD, K_ALU, K_CMP, K_INCX, K_LDB: st_q <= ST_MEMRD;
                        K_STORE, K_STB: st_q <= ST_MEMWR;
                        K_JUMP: begin
                            if (jmp_taken)
                                pc_q <= W'(ea_next);
                            st_q <= ST_FETCH;
                        end
                        K_CALL: begin
                            l_q  <= pc_q;
                            pc_q <= W'(ea_next);
                            st_q <= ST_FETCH;
                        end
                        K_RET: begin
                            pc_q <= l_q;
                            st_q <= ST_FETCH;
                        end
                        default: st_q <= ST_HALT;
                    endcase
                end
                ST_MEMRD: begin
                    if (cnt_q != '0)
                        mdr_q <= {mdr_q[W-BYTE_W-1:0], mem_rdata};
                    if (cnt_q == xfer_len) begin
                        cnt_q <= '0;
                        st_q  <= ST_EXEC;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_MEMWR: begin
                    if (cnt_q == xfer_len - CNT_W'(1)) begin
                        cnt_q <= '0;
                        st_q  <= ST_FETCH;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_EXEC: begin
                    case (dec.kind)
                        K_LOAD: begin
                            case (dec.rsel)
                                RS_X:    x_q <= mdr_q;
                                RS_L:    l_q <= mdr_q;
                                default: a_q <= mdr_q;
                            endcase
                        end
                        K_ALU:  a_q <= alu_res;
                        K_CMP:  cc_q <= alu_cc;
                        K_INCX: begin
                            x_q  <= x_inc;
                            cc_q <= alu_cc;
                        end
                        K_LDB:  a_q[BYTE_W-1:0] <= mdr_q[BYTE_W-1:0];
                        default: ;
                    endcase
                    st_q <= ST_FETCH;
                end
                default: st_q <= ST_HALT;
            endcase
        end
    end

endmodule

// File: rtl/acc_core_chk.sv
// Protocol checker for acc_core, attached by bind. Observes only the
// memory port and status outputs.
module acc_core_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              halted,
    input logic [1:0]        cond_code
);

    // R1: first cycle out of reset reads address 0
    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_rd_en && mem_addr == '0 && !halted));

    // R6: condition code never takes the unused value
    assert_cc_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cond_code != 2'b11);

    // R11: halt is sticky
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11: no memory traffic while halted
    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd_en && !mem_wr_en));

    // R12: one access per cycle
    assert_single_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R12: back-to-back reads walk up by one byte
    assert_rd_seq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R12: back-to-back writes walk up by one byte
    assert_wr_seq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .halted    (halted),
    .cond_code (cond_code)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;

    localparam logic [7:0] LDA = 8'h01, LDX = 8'h02, LDL = 8'h03;
    localparam logic [7:0] STA = 8'h04, STX = 8'h05, STL = 8'h06;
    localparam logic [7:0] LDB = 8'h07, STB = 8'h08;
    localparam logic [7:0] ADD = 8'h10, SUB = 8'h11, AND_ = 8'h12, OR_ = 8'h13;
    localparam logic [7:0] CMP = 8'h20, INCX = 8'h21;
    localparam logic [7:0] JMP = 8'h30, JLT = 8'h31, JEQ = 8'h32, JGT = 8'h33;
    localparam logic [7:0] CALL = 8'h34, RET = 8'h35, HLT = 8'hFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd_en, mem_wr_en, halted;
    logic [7:0]  mem_rdata, mem_wdata;
    logic [1:0]  cond_code;
    logic [7:0]  mem [0:32767];
    logic [23:0] vals [8];
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    acc_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_rdata (mem_rdata),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .halted    (halted),
        .cond_code (cond_code)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_ins(input int at, input logic [7:0] op, input bit x, input int a);
        mem[at] = op;
        mem[at+1] = {x, 7'(a >> 8)};
        mem[at+2] = 8'(a);
    endtask

    task automatic put_word(input int at, input logic [23:0] w);
        mem[at] = w[23:16];
        mem[at+1] = w[15:8];
        mem[at+2] = w[7:0];
    endtask

    function automatic logic [23:0] get_word(input int at);
        return {mem[at], mem[at+1], mem[at+2]};
    endfunction

    function automatic logic [1:0] exp_cc(input logic [23:0] l, input logic [23:0] r);
        if ($signed(l) < $signed(r)) return 2'b00;
        if (l == r) return 2'b01;
        return 2'b10;
    endfunction

    // Enter reset and clear the low memory area.
    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    // Release reset and run until halt or limit; counts read cycles.
    task automatic run(input int limit, output int reads, output bit done);
        reads = 0;
        done = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < limit; c++) begin
            if (halted) begin
                done = 1'b1;
                break;
            end
            if (mem_rd_en) reads++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  rd;
        bit  dn;
        logic [23:0] e;
        vals[0] = 24'h000000; vals[1] = 24'h000001; vals[2] = 24'h7FFFFF;
        vals[3] = 24'h800000; vals[4] = 24'hFFFFFF; vals[5] = 24'h123456;
        vals[6] = 24'h00FF00; vals[7] = 24'hABCDEF;

        // R1 / R2: reset state and fetch byte order
        hold_reset();
        mem[0] = HLT;
        chk("R1 halted", {31'b0, halted}, 0);
        chk("R1 cc", {30'b0, cond_code}, 0);
        chk("R1 first read", {16'b0, mem_rd_en, mem_addr}, {16'b0, 1'b1, 15'd0});
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R2 fetch addr", {16'b0, mem_rd_en, mem_addr}, {16'b0, 1'b1, 15'(k)});
            @(negedge clk);
        end
        chk("R2 fetch ends", {31'b0, mem_rd_en}, 0);

        // R5: arithmetic and logic sweep
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    hold_reset();
                    put_ins(0, LDA, 0, 'h100);
                    put_ins(3, 8'(ADD + o), 0, 'h103);
                    put_ins(6, STA, 0, 'h106);
                    mem[9] = HLT;
                    put_word('h100, vals[i]);
                    put_word('h103, vals[j]);
                    run(200, rd, dn);
                    case (o)
                        0: e = vals[i] + vals[j];
                        1: e = vals[i] - vals[j];
                        2: e = vals[i] & vals[j];
                        default: e = vals[i] | vals[j];
                    endcase
                    chk("R5 alu result", get_word('h106), e);
                end
            end
        end

        // R6 / R8: compare then both jump orderings
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [1:0] c;
                    hold_reset();
                    put_ins(0, LDA, 0, 'h100);
                    put_ins(3, CMP, 0, 'h103);
                    put_ins(6, (v == 0) ? JGT : JLT, 0, 'h20);
                    put_ins(9, JEQ, 0, 'h30);
                    put_ins(12, JMP, 0, 'h40);
                    put_ins('h20, LDA, 0, 'h110); put_ins('h23, STA, 0, 'h106); mem['h26] = HLT;
                    put_ins('h30, LDA, 0, 'h113); put_ins('h33, STA, 0, 'h106); mem['h36] = HLT;
                    put_ins('h40, LDA, 0, 'h116); put_ins('h43, STA, 0, 'h106); mem['h46] = HLT;
                    put_word('h100, vals[i]);
                    put_word('h103, vals[j]);
                    put_word('h110, 24'h000111);
                    put_word('h113, 24'h000222);
                    put_word('h116, 24'h000333);
                    run(300, rd, dn);
                    c = exp_cc(vals[i], vals[j]);
                    chk("R6 cond code", {30'b0, cond_code}, {30'b0, c});
                    if (c == 2'b01) e = 24'h000222;
                    else if ((c == 2'b10) == (v == 0)) e = 24'h000111;
                    else e = 24'h000333;
                    chk("R8 branch path", get_word('h106), e);
                end
            end
        end

        // R7 / R4: increment-and-compare on X with X load/store
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                hold_reset();
                put_ins(0, LDX, 0, 'h100);
                put_ins(3, INCX, 0, 'h103);
                put_ins(6, STX, 0, 'h106);
                mem[9] = HLT;
                put_word('h100, vals[i]);
                put_word('h103, vals[j]);
                run(200, rd, dn);
                e = vals[i] + 24'd1;
                chk("R7 x incremented", get_word('h106), e);
                chk("R7 cond code", {30'b0, cond_code}, {30'b0, exp_cc(e, vals[j])});
            end
        end

        // R3: indexed addressing over byte offsets, plus wrap
        for (int i = 0; i < 22; i++) begin
            hold_reset();
            for (int k = 0; k < 32; k++) mem['h200 + k] = 8'(k * 7 + 3);
            put_ins(0, LDX, 0, 'h100);
            put_ins(3, LDA, 1, 'h200);
            put_ins(6, STA, 0, 'h106);
            mem[9] = HLT;
            put_word('h100, 24'(i));
            run(200, rd, dn);
            chk("R3 indexed load", get_word('h106), get_word('h200 + i));
        end
        hold_reset();
        put_word('h200, 24'h5A6B7C);
        put_ins(0, LDX, 0, 'h100);
        put_ins(3, LDA, 1, 'h7FFF);
        put_ins(6, STA, 0, 'h106);
        mem[9] = HLT;
        put_word('h100, 24'h000201);
        run(200, rd, dn);
        chk("R3 address wrap", get_word('h106), 24'h5A6B7C);

        // R9: call saves return address, return resumes after call
        hold_reset();
        put_ins(0, CALL, 0, 'h40);
        put_ins(3, STL, 0, 'h106);
        mem[6] = HLT;
        put_ins('h40, RET, 0, 0);
        run(200, rd, dn);
        chk("R9 link saved and returned", get_word('h106), 24'h000003);
        chk("R9 halted after return", {31'b0, dn}, 1);

        // R4 / R9: L loaded from memory then return through it
        hold_reset();
        put_ins(0, LDL, 0, 'h100);
        put_ins(3, RET, 0, 0);
        mem[6] = HLT;
        put_word('h100, 24'h000050);
        put_ins('h50, LDA, 0, 'h110);
        put_ins('h53, STA, 0, 'h106);
        mem['h56] = HLT;
        put_word('h110, 24'hC0FFEE);
        run(200, rd, dn);
        chk("R9 return via loaded L", get_word('h106), 24'hC0FFEE);

        // R10 / R4: byte load/store and big-endian word store
        hold_reset();
        put_ins(0, LDA, 0, 'h100);
        put_ins(3, LDB, 0, 'h103);
        put_ins(6, STA, 0, 'h106);
        put_ins(9, STB, 0, 'h301);
        mem[12] = HLT;
        put_word('h100, 24'h123456);
        mem['h103] = 8'h9E;
        mem['h300] = 8'hAA; mem['h301] = 8'hBB; mem['h302] = 8'hCC;
        run(200, rd, dn);
        chk("R10 byte load keeps upper", get_word('h106), 24'h12349E);
        chk("R4 store msb first", {24'b0, mem['h106]}, 32'h12);
        chk("R10 byte store target", {24'b0, mem['h301]}, 32'h9E);
        chk("R10 byte store left", {24'b0, mem['h300]}, 32'hAA);
        chk("R10 byte store right", {24'b0, mem['h302]}, 32'hCC);

        // R11: every opcode value; undefined halts after its fetch
        for (int op = 0; op < 256; op++) begin
            bit defd;
            defd = (op >= 1 && op <= 8) || (op >= 'h10 && op <= 'h13) ||
                   op == 'h20 || op == 'h21 || (op >= 'h30 && op <= 'h35);
            hold_reset();
            put_ins(0, 8'(op), 0, 'h100);
            mem[3] = HLT;
            run(40, rd, dn);
            if (defd) chk("R11 defined opcode continues", {31'b0, rd > 3}, 1);
            else chk("R11 undefined opcode reads", rd, 3);
        end

        // R11: halt is sticky and quiet
        hold_reset();
        mem[0] = 8'h77;
        run(50, rd, dn);
        chk("R11 halted", {31'b0, dn}, 1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R11 quiet while halted", {30'b0, halted, mem_rd_en | mem_wr_en}, 32'b10);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule